// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block keeps one free-running 32-bit tick counter and a set of compare channels behind a flat 32-bit register port. Software starts or stops the counter with a global enable bit, loads the counter while it is stopped, and programs each channel with a compare value, a trigger style and a destination interrupt line. When the counter equals a channel's compare value, that channel signals an interrupt either as a held level, latched in a write-one-to-clear status register, or as a single-cycle pulse.

A channel may run one-shot, where the compare value stays put after the hit, or periodic, where the compare value moves forward by a stored period after every hit. To load a periodic channel, software sets a self-clearing value-set bit. The next compare write then gives the first hit time and the write after it gives the period. A fixed routing mode can be turned on in the global configuration. It sends channel 0 to line 0 and channel 1 to line 8, whatever their own route fields hold. Each channel also has a read-only mask of the lines it is allowed to use.

Register map (byte offsets): identity word 0x000, tick period in femtoseconds 0x004, global configuration 0x010 (bit 0 run, bit 1 fixed routing), status 0x020 (bit n for channel n), counter 0x0F0. Channel n: configuration at 0x100+0x20·n, route mask at +4, compare at +8. Channel configuration bits: 1 level trigger, 2 interrupt enable, 3 periodic, 4 periodic-capable (read-only), 6 value-set, 8 force-32-bit (stored only), 13:9 destination line.

Top module: `evt_timer`

## Requirements
- R1: The identity word reads the vendor code in bits 31:16, a fixed-routing-capable flag in bit 15, a 64-bit-counter flag of 0 in bit 13, the channel count minus one in bits 12:8 and the revision in bits 7:0. With the default parameters it reads 0x5A178203. The period register reads 0x02FAF080. The periodic-capable bit (4) of a channel configuration is read-only: channels 0 and 1 read 1 and channel 2 reads 0, even after 1 is written there.
- R2: After reset the configuration, status and counter read 0, the compares read 0xFFFFFFFF and all interrupt lines are low. While the run bit is set, the counter increases by one each clock and ignores writes. While the run bit is clear, the counter holds its value and a write loads it.
- R3: A level-triggered channel with interrupt enable sets its status bit on the clock after the counter equals its compare. Its routed line stays high until 1 is written to that status bit. Writing 0 to the status bit changes nothing.
- R4: An edge-triggered channel with interrupt enable drives its routed line high for exactly one clock after a hit, and its status bit stays 0.
- R5: In one-shot mode the compare value is unchanged after a hit and the channel raises no further interrupt.
- R6: In periodic mode, writing the configuration with value-set 1 arms the channel. The next compare write loads the hit value and clears value-set, so the configuration then reads bit 6 as 0. The write after that loads the period, and each hit advances the compare by that period.
- R7: With fixed routing set in the global configuration, channel 0 drives only line 0 and channel 1 drives only line 8, whatever their route fields hold.
- R8: A channel whose interrupt enable is clear raises neither a status bit nor a line when it hits.
- R9: While the run bit is clear, no hit is detected, even if the counter equals a compare value.
- R10: A route to a line outside the channel's mask drives no line, but a level channel still sets its status bit. The default masks are 0x000000F0, 0x00000F00 and 0x0000F000 for channels 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_lines | output | NUM_IRQ | Interrupt output lines |

## Verification
Some properties are checked on every cycle. The counter steps by one while running and holds while stopped. A latched status bit stays set until it is cleared by a write. Value-set always clears on the next compare write. A one-shot compare never moves by itself. A periodic hit advances the compare by exactly the period. An edge hit never sets status. Fixed routing always reaches line 0 while channel 0 is asserted. Other behaviour can only be shown by the bench's scenarios. These are the exact clock on which a line rises for a given counter start and compare value, and the one-clock width of edge pulses. They also include the two-write periodic load sequence and what a masked route, a disabled interrupt or a stopped counter leave at the ports.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int DW = 32;
   localparam int AW = 12;

   localparam logic [AW-1:0] OFS_ID   = 12'h000;
   localparam logic [AW-1:0] OFS_TICK = 12'h004;
   localparam logic [AW-1:0] OFS_GCFG = 12'h010;
   localparam logic [AW-1:0] OFS_STS  = 12'h020;
   localparam logic [AW-1:0] OFS_CNT  = 12'h0F0;
   localparam int CH_BASE   = 256;
   localparam int CH_STRIDE = 32;
   localparam int SUB_CFG   = 0;
   localparam int SUB_MASK  = 4;
   localparam int SUB_CMP   = 8;

   localparam int G_RUN = 0;
   localparam int G_FIX = 1;

   localparam int B_LVL  = 1;
   localparam int B_IEN  = 2;
   localparam int B_PER  = 3;
   localparam int B_PCAP = 4;
   localparam int B_VS   = 6;
   localparam int B_F32  = 8;
   localparam int B_RT   = 9;
   localparam int RT_W   = 5;

   localparam int ID_FIXCAP = 15;
   localparam int ID_NCH    = 8;

   function automatic logic [AW-1:0] ch_addr(input int idx, input int sub);
      return AW'(CH_BASE + CH_STRIDE * idx + sub);
   endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] value
);
   if (W < 8) begin : g_bad_width
      $error("evt_counter: W must be at least 8");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     value <= '0;
      else if (run)   value <= value + W'(1);
      else if (load)  value <= load_val;
   end

   // R2: running counter steps by one every clock
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> value == $past(value) + W'(1));
   // R2: stopped counter without a load holds
   a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(value));
endmodule

// File: rtl/evt_channel.sv
module evt_channel import evt_pkg::*; #(
   parameter bit PER_CAP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cnt_run,
   input  logic [DW-1:0]   cnt,
   input  logic            cfg_we,
   input  logic            cmp_we,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   cfg_word,
   output logic [DW-1:0]   cmp_val,
   output logic            irq_hit,
   output logic            is_level,
   output logic [RT_W-1:0] route
);
   logic lvl, ien, per, vs, f32;
   logic [RT_W-1:0] rt;
   logic [DW-1:0] cmp;
   logic [DW-1:0] period;
   logic want_period;
   logic match, reload, cmp_load;

   assign match    = cnt_run && (cnt == cmp);
   assign reload   = PER_CAP && match && per;
   assign cmp_load = cmp_we && (!want_period || (vs && per));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl <= 1'b0; ien <= 1'b0; per <= 1'b0; vs <= 1'b0; f32 <= 1'b0;
         rt  <= '0;
      end else if (cfg_we) begin
         lvl <= wdata[B_LVL];
         ien <= wdata[B_IEN];
         per <= wdata[B_PER];
         vs  <= wdata[B_VS];
         f32 <= wdata[B_F32];
         rt  <= wdata[B_RT +: RT_W];
      end else if (cmp_we) begin
         vs  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cmp <= '1;
      else if (cmp_load) cmp <= wdata;
      else if (reload)   cmp <= cmp + period;
   end

   if (PER_CAP) begin : g_periodic
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            want_period <= 1'b0;
            period      <= '0;
         end else if (cfg_we) begin
            want_period <= 1'b0;
         end else if (cmp_we) begin
            if (vs && per) begin
               want_period <= 1'b1;
            end else if (want_period) begin
               period      <= wdata;
               want_period <= 1'b0;
            end
         end
      end

      // R6: a periodic hit moves the compare forward by the period
      a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
         (match && per && !cmp_we) |=> cmp == $past(cmp) + $past(period));
   end else begin : g_oneshot_only
      assign want_period = 1'b0;
      assign period      = '0;
   end

   always_comb begin
      cfg_word = '0;
      cfg_word[B_LVL]  = lvl;
      cfg_word[B_IEN]  = ien;
      cfg_word[B_PER]  = per;
      cfg_word[B_PCAP] = PER_CAP;
      cfg_word[B_VS]   = vs;
      cfg_word[B_F32]  = f32;
      cfg_word[B_RT +: RT_W] = rt;
   end

   assign cmp_val  = cmp;
   assign irq_hit  = match && ien;
   assign is_level = lvl;
   assign route    = rt;

   // R6: value-set clears on the compare write that follows it
   a_r6_vs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (vs && cmp_we) |=> !vs);
   // R5: a one-shot compare never moves without a write
   a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!per && !cmp_we) |=> $stable(cmp));
endmodule

// File: rtl/evt_timer.sv
module evt_timer import evt_pkg::*; #(
   parameter int              NUM_CH      = 3,
   parameter int              NUM_IRQ     = 16,
   parameter logic [31:0]     TICK_FS     = 32'd50_000_000,
   parameter logic [15:0]     VENDOR      = 16'h5A17,
   parameter logic [7:0]      REVISION    = 8'h03,
   parameter bit              FIX_CAP     = 1'b1,
   parameter logic [NUM_CH-1:0]    PER_CAPS    = 3'b011,
   parameter logic [NUM_CH*32-1:0] ROUTE_MASKS = {32'h0000F000, 32'h00000F00, 32'h000000F0}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      bus_addr,
   input  logic               bus_wr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   output logic [NUM_IRQ-1:0] irq_lines
);
   localparam logic [DW-1:0] ID_WORD =
      {VENDOR, FIX_CAP, 1'b0, 1'b0, 5'(NUM_CH - 1), REVISION};

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_nch
      $error("evt_timer: NUM_CH must be 1..32");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_nirq
      $error("evt_timer: NUM_IRQ must be 1..32");
   end
   if (TICK_FS == 0 || TICK_FS > 32'd100_000_000) begin : g_bad_tick
      $error("evt_timer: tick period must be nonzero and give at least 10 MHz");
   end
   if (FIX_CAP && (NUM_IRQ < 9 || NUM_CH < 2)) begin : g_bad_fix
      $error("evt_timer: fixed routing needs 9 lines and 2 channels");
   end

   logic run_q, fix_q;
   logic [DW-1:0] cnt;
   logic gcfg_we, cnt_load;
   logic [NUM_CH-1:0] hit, lvl, st_q, edge_q, st_clr, asserted, ok;
   logic [DW-1:0] cfg_word [NUM_CH];
   logic [DW-1:0] cmp_val  [NUM_CH];
   logic [RT_W-1:0] route  [NUM_CH];
   logic [RT_W-1:0] dest   [NUM_CH];

   assign gcfg_we  = bus_wr && (bus_addr == OFS_GCFG);
   assign cnt_load = bus_wr && (bus_addr == OFS_CNT) && !run_q;
   assign st_clr   = (bus_wr && bus_addr == OFS_STS) ? bus_wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         fix_q <= 1'b0;
      end else if (gcfg_we) begin
         run_q <= bus_wdata[G_RUN];
         fix_q <= bus_wdata[G_FIX] & FIX_CAP;
      end
   end

   evt_counter #(.W(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run_q), .load(cnt_load),
      .load_val(bus_wdata), .value(cnt)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [31:0] MASK_C = ROUTE_MASKS[c*32 +: 32];
      logic cfg_we_c, cmp_we_c;
      assign cfg_we_c = bus_wr && (bus_addr == ch_addr(c, SUB_CFG));
      assign cmp_we_c = bus_wr && (bus_addr == ch_addr(c, SUB_CMP));

      evt_channel #(.PER_CAP(PER_CAPS[c])) u_ch (
         .clk(clk), .rst_n(rst_n), .cnt_run(run_q), .cnt(cnt),
         .cfg_we(cfg_we_c), .cmp_we(cmp_we_c), .wdata(bus_wdata),
         .cfg_word(cfg_word[c]), .cmp_val(cmp_val[c]),
         .irq_hit(hit[c]), .is_level(lvl[c]), .route(route[c])
      );

      if (FIX_CAP && c < 2) begin : g_fixed
         localparam logic [RT_W-1:0] FIX_LINE = (c == 0) ? RT_W'(0) : RT_W'(8);
         assign dest[c] = fix_q ? FIX_LINE : route[c];
         assign ok[c]   = fix_q ? 1'b1 : MASK_C[route[c]];
      end else begin : g_free
         assign dest[c] = route[c];
         assign ok[c]   = MASK_C[route[c]];
      end

      // R3: a latched status bit survives until a 1 is written to it
      a_r3_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[c] && !st_clr[c]) |=> st_q[c]);
      // R4: an edge hit leaves status untouched
      a_r4_edge_no_status: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_q[c] && !$past(st_q[c])) |-> !st_q[c]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= '0;
         edge_q <= '0;
      end else begin
         st_q   <= (st_q & ~st_clr) | (hit & lvl);
         edge_q <= hit & ~lvl;
      end
   end

   assign asserted = st_q | edge_q;

   always_comb begin
      irq_lines = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         for (int l = 0; l < NUM_IRQ; l++) begin
            if (asserted[c] && ok[c] && dest[c] == RT_W'(l)) irq_lines[l] = 1'b1;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_ID:   bus_rdata = ID_WORD;
         OFS_TICK: bus_rdata = TICK_FS;
         OFS_GCFG: bus_rdata = {30'b0, fix_q, run_q};
         OFS_STS:  bus_rdata = DW'(st_q);
         OFS_CNT:  bus_rdata = cnt;
         default:  bus_rdata = '0;
      endcase
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ch_addr(c, SUB_CFG))  bus_rdata = cfg_word[c];
         if (bus_addr == ch_addr(c, SUB_MASK)) bus_rdata = ROUTE_MASKS[c*32 +: 32];
         if (bus_addr == ch_addr(c, SUB_CMP))  bus_rdata = cmp_val[c];
      end
   end

   if (FIX_CAP) begin : g_fix_chk
      // R7: with fixed routing, an asserted channel 0 always reaches line 0
      a_r7_fixed_line0: assert property (@(posedge clk) disable iff (!rst_n)
         (fix_q && asserted[0]) |-> irq_lines[0]);
   end
endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] irq_lines;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   evt_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines)
   );

   localparam logic [11:0] A_ID = 12'h000, A_TICK = 12'h004, A_GCFG = 12'h010,
                           A_STS = 12'h020, A_CNT = 12'h0F0;
   localparam logic [11:0] C0_CFG = 12'h100, C0_CMP = 12'h108,
                           C1_CFG = 12'h120, C1_CMP = 12'h128,
                           C2_CFG = 12'h140, C2_CMP = 12'h148;

   // {is_write, address, write data or expected read}
   localparam int NV = 18;
   localparam logic [44:0] VEC [NV] = '{
      {1'b0, 12'h000, 32'h5A178203},
      {1'b0, 12'h004, 32'h02FAF080},
      {1'b0, 12'h010, 32'h00000000},
      {1'b0, 12'h020, 32'h00000000},
      {1'b0, 12'h0F0, 32'h00000000},
      {1'b0, 12'h100, 32'h00000010},
      {1'b0, 12'h104, 32'h000000F0},
      {1'b0, 12'h108, 32'hFFFFFFFF},
      {1'b0, 12'h124, 32'h00000F00},
      {1'b0, 12'h144, 32'h0000F000},
      {1'b0, 12'h140, 32'h00000000},
      {1'b1, 12'h140, 32'h00001810},
      {1'b0, 12'h140, 32'h00001800},
      {1'b1, 12'h0F0, 32'h00001234},
      {1'b0, 12'h0F0, 32'h00001234},
      {1'b1, 12'h010, 32'h00000002},
      {1'b0, 12'h010, 32'h00000002},
      {1'b1, 12'h010, 32'h00000000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // waits for a line; returns the counter value on the first clock it is high
   task automatic wait_line(input int l, output logic [31:0] cnt_at, output bit seen);
      seen = 1'b0;
      cnt_at = '0;
      for (int i = 0; i < 100 && !seen; i++) begin
         @(negedge clk);
         bus_addr = A_CNT;
         #1;
         if (irq_lines[l]) begin
            seen = 1'b1;
            cnt_at = bus_rdata;
         end
      end
   endtask

   task automatic stop_at(input logic [31:0] start);
      wr(A_GCFG, 32'h0);
      wr(A_CNT, start);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c0, c1, at;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state of the lines
      check("R2 reset lines", 32'(irq_lines), 32'h0);

      // R1 and R2: register table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
         else begin
            rd(VEC[i][43:32], v);
            check($sformatf("R1/R2 table[%0d]", i), v, VEC[i][31:0]);
         end
      end

      // R2: counting, write ignored while running, hold while stopped
      wr(A_GCFG, 32'h1);
      rd(A_CNT, c0);
      repeat (5) @(negedge clk);
      rd(A_CNT, c1);
      check("R2 count step", c1, c0 + 32'd5);
      rd(A_CNT, c0);
      wr(A_CNT, 32'h0);
      rd(A_CNT, c1);
      check("R2 write ignored while running", c1, c0 + 32'd1);
      wr(A_GCFG, 32'h0);
      rd(A_CNT, c0);
      repeat (4) @(negedge clk);
      rd(A_CNT, c1);
      check("R2 hold while stopped", c1, c0);

      // R9: equal compare with counter stopped
      wr(C2_CFG, 32'h00001806);
      wr(C2_CMP, c0);
      repeat (5) @(negedge clk);
      rd(A_STS, v);
      check("R9 no status when stopped", v, 32'h0);
      check("R9 no line when stopped", 32'(irq_lines), 32'h0);
      wr(C2_CFG, 32'h0);

      // R3: level channel 0 on line 4
      stop_at(32'd100);
      wr(C0_CFG, 32'h00000806);
      wr(C0_CMP, 32'd110);
      wr(A_GCFG, 32'h1);
      wait_line(4, at, seen);
      check("R3 level seen", 32'(seen), 32'h1);
      check("R3 level timing", at, 32'd111);
      check("R3 only line 4", 32'(irq_lines), 32'h0010);
      repeat (3) @(negedge clk);
      check("R3 level held", 32'(irq_lines[4]), 32'h1);
      wr(A_STS, 32'h0);
      rd(A_STS, v);
      check("R3 write 0 no effect", v, 32'h1);
      check("R3 line kept after 0 write", 32'(irq_lines[4]), 32'h1);
      wr(A_STS, 32'h1);
      rd(A_STS, v);
      check("R3 cleared", v, 32'h0);
      check("R3 line dropped", 32'(irq_lines[4]), 32'h0);

      // R5: one-shot does not reload
      rd(C0_CMP, v);
      check("R5 compare unchanged", v, 32'd110);
      repeat (20) @(negedge clk);
      rd(A_STS, v);
      check("R5 no second hit", v, 32'h0);

      // R4: edge channel 1 on line 9
      stop_at(32'd200);
      wr(C1_CFG, 32'h00001204);
      wr(C1_CMP, 32'd205);
      wr(A_GCFG, 32'h1);
      wait_line(9, at, seen);
      check("R4 edge seen", 32'(seen), 32'h1);
      check("R4 edge timing", at, 32'd206);
      @(negedge clk);
      check("R4 one-clock pulse", 32'(irq_lines[9]), 32'h0);
      rd(A_STS, v);
      check("R4 status stays 0", v, 32'h0);

      // R6: periodic two-write sequence on channel 1
      stop_at(32'd300);
      wr(C1_CFG, 32'h0000124C);
      rd(C1_CFG, v);
      check("R6 value-set armed", v, 32'h0000125C);
      wr(C1_CMP, 32'd310);
      rd(C1_CFG, v);
      check("R6 value-set self-clears", v, 32'h0000121C);
      wr(C1_CMP, 32'd7);
      rd(C1_CMP, v);
      check("R6 period write keeps match", v, 32'd310);
      wr(A_GCFG, 32'h1);
      wait_line(9, at, seen);
      check("R6 first hit", at, 32'd311);
      rd(C1_CMP, v);
      check("R6 compare advanced", v, 32'd317);
      wait_line(9, at, seen);
      check("R6 second hit", at, 32'd318);
      wr(C1_CFG, 32'h0);

      // R8: interrupt enable clear on channel 2
      stop_at(32'd400);
      wr(C2_CFG, 32'h00001802);
      wr(C2_CMP, 32'd405);
      wr(A_GCFG, 32'h1);
      repeat (15) @(negedge clk);
      rd(A_STS, v);
      check("R8 no status", v, 32'h0);
      check("R8 no line", 32'(irq_lines), 32'h0);

      // R10: route outside mask on channel 0 (line 2)
      stop_at(32'd500);
      wr(C0_CFG, 32'h00000406);
      wr(C0_CMP, 32'd505);
      wr(A_GCFG, 32'h1);
      repeat (15) @(negedge clk);
      rd(A_STS, v);
      check("R10 status still set", v, 32'h1);
      check("R10 no line driven", 32'(irq_lines), 32'h0);
      wr(A_STS, 32'h1);

      // R7: fixed routing for channels 0 and 1
      stop_at(32'd600);
      wr(C0_CFG, 32'h00000806);
      wr(C0_CMP, 32'd605);
      wr(C1_CFG, 32'h00001204);
      wr(C1_CMP, 32'd608);
      wr(A_GCFG, 32'h3);
      wait_line(0, at, seen);
      check("R7 channel 0 on line 0", at, 32'd606);
      check("R7 only line 0", 32'(irq_lines), 32'h0001);
      wait_line(8, at, seen);
      check("R7 channel 1 on line 8", at, 32'd609);
      check("R7 lines 0 and 8 only", 32'(irq_lines), 32'h0101);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule